// File: doc/BRIEF.md
# Flash Word Programming Sequencer

This block writes a run of consecutive words into a NOR-style flash device, one word after another, with no fixed waiting time anywhere in the loop. After a start pulse it takes a base address and a word count. It then requests each data word from the user through a valid/ready handshake. For every word it drives the four-write program command onto a synchronous flash bus. It then reads the target location again and again until the returned data equals the word it wrote. Only after that match does it step to the next address.

When the last word has been confirmed, the block gives a one-cycle completion pulse and returns to idle. A device that never confirms a word is caught by a per-word poll budget. When that budget runs out, the block raises a sticky error flag and stops all bus traffic. The flag stays set until the next start.

Top module: `flash_prog_loop`

## Requirements
- R1: A start pulse taken while idle with a non-zero `word_count` raises `busy`. A start pulse with `word_count` equal to zero produces `done` on the next cycle, leaves `busy` low and causes no bus access.
- R2: For each word the block raises `wd_ready` and waits for `wd_valid`. No bus write for that word happens before the handshake completes, however long the user delays.
- R3: After a word is accepted, four bus writes follow on consecutive cycles. They are, in this order: 0x00AA to address 0x555, 0x0055 to address 0x2AA, 0x00A0 to address 0x555, and then the accepted word to the target address. The first write appears in the same cycle in which `wd_ready` falls.
- R4: The cycle after the fourth write carries a read strobe at the target address. Read data is compared in the cycle after each strobe. While the data differs from the word, reads of the same address repeat every second cycle and no command is issued again. The number of reads for a word is therefore one more than the number of non-matching replies.
- R5: A matching read advances the target address by one. Word i of a run lands at address base_addr + i.
- R6: When the last word matches, `done` is high for exactly one cycle and `busy` is low from that cycle on.
- R7: Each word gets at most MAX_POLLS reads. If none of them matches, `error` is set, `busy` drops, and no further bus or handshake activity follows. The remaining addresses are left untouched. `error` clears at the next start.
- R8: A start pulse that arrives while `busy` is high is ignored. The run in progress keeps its addresses and its count.
- R9: `bus_we` and `bus_re` are never high in the same cycle.
- R10: After the synchronous active-high reset, `busy`, `done`, `error`, `wd_ready`, `bus_we` and `bus_re` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when idle |
| base_addr | input | ADDR_W | First target address, taken at start |
| word_count | input | LEN_W | Number of words in the run, taken at start |
| wd_valid | input | 1 | User offers the next data word |
| wd_data | input | DATA_W | Next data word |
| wd_ready | output | 1 | Sequencer waits for the next word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the whole run is confirmed |
| error | output | 1 | Sticky flag: a word was not confirmed within its poll budget |
| bus_we | output | 1 | One-cycle write strobe to the flash |
| bus_re | output | 1 | One-cycle read strobe to the flash |
| bus_addr | output | ADDR_W | Flash bus address |
| bus_wdata | output | DATA_W | Flash bus write data |
| bus_rdata | input | DATA_W | Flash read data, valid the cycle after `bus_re` |

## Verification
The flash model answers each poll with the complement of the pending word for a chosen number of reads and then commits the word. Varying that number per word checks that the read count tracks the device's delay exactly and that the address never advances early. Directed words 0x0000, 0xFFFF and 0x00AA, a target range that covers the command address 0x555, and a long delay before the first valid show whether the comparison and the command decoding are confused by the data, and whether the handshake really gates the bus. Random runs vary the base, length, data and handshake gaps. A start pulse in mid-run, a zero-length request and a device that never completes test R8, R1 and the budget and stop rule of R7.

// File: rtl/flashprog_pkg.sv
package flashprog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_UNLK2,
    ST_SETUP,
    ST_DATA,
    ST_POLL,
    ST_WAIT,
    ST_CHECK
  } seq_state_t;

  localparam logic [7:0] UNLOCK_BYTE_1 = 8'hAA;
  localparam logic [7:0] UNLOCK_BYTE_2 = 8'h55;
  localparam logic [7:0] PROGRAM_BYTE  = 8'hA0;

endpackage

// File: rtl/fpl_addr_ctr.sv
module fpl_addr_ctr #(
  parameter int ADDR_W = 22,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  count,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      remain <= '0;
    end else if (load) begin
      addr   <= base;
      remain <= count;
    end else if (step) begin
      addr   <= addr + ADDR_W'(1);
      remain <= remain - LEN_W'(1);
    end
  end

  assign last = (remain == LEN_W'(1));

endmodule

// File: rtl/fpl_poll_ctr.sv
module fpl_poll_ctr #(
  parameter int MAX_POLLS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic expired
);

  localparam int CW = $clog2(MAX_POLLS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && !expired) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign expired = (cnt >= CW'(MAX_POLLS));

endmodule

// File: rtl/fpl_seq.sv
module fpl_seq
  import flashprog_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int CMD_ADDR_A = 'h555,
  parameter int CMD_ADDR_B = 'h2AA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              count_zero,
  input  logic              wd_valid,
  input  logic [DATA_W-1:0] wd_data,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              last,
  input  logic              expired,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              wd_ready,
  output logic              bus_we,
  output logic              bus_re,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              ctr_load,
  output logic              ctr_step,
  output logic              poll_clr,
  output logic              poll_inc
);

  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(CMD_ADDR_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(CMD_ADDR_B);
  localparam logic [DATA_W-1:0] DAT_1 = DATA_W'(UNLOCK_BYTE_1);
  localparam logic [DATA_W-1:0] DAT_2 = DATA_W'(UNLOCK_BYTE_2);
  localparam logic [DATA_W-1:0] DAT_P = DATA_W'(PROGRAM_BYTE);

  seq_state_t        state;
  logic [DATA_W-1:0] word_q;
  logic              match;

  assign match    = (bus_rdata == word_q);
  assign ctr_load = (state == ST_IDLE) && start;
  assign ctr_step = (state == ST_CHECK) && match && !last;
  assign poll_clr = (state == ST_FETCH) && wd_valid;
  assign poll_inc = (state == ST_POLL) ||
                    ((state == ST_CHECK) && !match && !expired);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      word_q    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      wd_ready  <= 1'b0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      done   <= 1'b0;
      bus_we <= 1'b0;
      bus_re <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            error <= 1'b0;
            if (count_zero) begin
              done <= 1'b1;
            end else begin
              busy     <= 1'b1;
              wd_ready <= 1'b1;
              state    <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (wd_valid) begin
            word_q    <= wd_data;
            wd_ready  <= 1'b0;
            bus_we    <= 1'b1;
            bus_addr  <= ADR_A;
            bus_wdata <= DAT_1;
            state     <= ST_UNLK2;
          end
        end
        ST_UNLK2: begin
          bus_we    <= 1'b1;
          bus_addr  <= ADR_B;
          bus_wdata <= DAT_2;
          state     <= ST_SETUP;
        end
        ST_SETUP: begin
          bus_we    <= 1'b1;
          bus_addr  <= ADR_A;
          bus_wdata <= DAT_P;
          state     <= ST_DATA;
        end
        ST_DATA: begin
          bus_we    <= 1'b1;
          bus_addr  <= tgt_addr;
          bus_wdata <= word_q;
          state     <= ST_POLL;
        end
        ST_POLL: begin
          bus_re   <= 1'b1;
          bus_addr <= tgt_addr;
          state    <= ST_WAIT;
        end
        ST_WAIT: begin
          state <= ST_CHECK;
        end
        ST_CHECK: begin
          if (match) begin
            if (last) begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              wd_ready <= 1'b1;
              state    <= ST_FETCH;
            end
          end else if (expired) begin
            error <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            bus_re   <= 1'b1;
            bus_addr <= tgt_addr;
            state    <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_prog_loop.sv
module flash_prog_loop #(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int LEN_W      = 16,
  parameter int MAX_POLLS  = 1000,
  parameter int CMD_ADDR_A = 'h555,
  parameter int CMD_ADDR_B = 'h2AA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  word_count,
  input  logic              wd_valid,
  input  logic [DATA_W-1:0] wd_data,
  output logic              wd_ready,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              bus_we,
  output logic              bus_re,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);

  logic [ADDR_W-1:0] tgt_addr;
  logic              last;
  logic              expired;
  logic              ctr_load;
  logic              ctr_step;
  logic              poll_clr;
  logic              poll_inc;
  logic              count_zero;

  assign count_zero = (word_count == '0);

  fpl_addr_ctr #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) u_addr (
    .clk   (clk),
    .rst   (rst),
    .load  (ctr_load),
    .step  (ctr_step),
    .base  (base_addr),
    .count (word_count),
    .addr  (tgt_addr),
    .last  (last)
  );

  fpl_poll_ctr #(
    .MAX_POLLS (MAX_POLLS)
  ) u_poll (
    .clk     (clk),
    .rst     (rst),
    .clr     (poll_clr),
    .inc     (poll_inc),
    .expired (expired)
  );

  fpl_seq #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CMD_ADDR_A (CMD_ADDR_A),
    .CMD_ADDR_B (CMD_ADDR_B)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .count_zero (count_zero),
    .wd_valid   (wd_valid),
    .wd_data    (wd_data),
    .tgt_addr   (tgt_addr),
    .last       (last),
    .expired    (expired),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .wd_ready   (wd_ready),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ctr_load   (ctr_load),
    .ctr_step   (ctr_step),
    .poll_clr   (poll_clr),
    .poll_inc   (poll_inc)
  );

endmodule

// File: rtl/fpl_checker.sv
module fpl_checker #(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int LEN_W      = 16,
  parameter int MAX_POLLS  = 1000,
  parameter int CMD_ADDR_A = 'h555,
  parameter int CMD_ADDR_B = 'h2AA
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [LEN_W-1:0]  word_count,
  input logic              wd_ready,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              bus_we,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);

  localparam int RW = $clog2(MAX_POLLS + 2);
  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(CMD_ADDR_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(CMD_ADDR_B);

  logic [RW-1:0] reads_since_wr;

  always_ff @(posedge clk) begin
    if (rst || bus_we) begin
      reads_since_wr <= '0;
    end else if (bus_re && (reads_since_wr <= RW'(MAX_POLLS))) begin
      reads_since_wr <= reads_since_wr + RW'(1);
    end
  end

  a_r1_zero_len: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (word_count == '0)) |=> (done && !busy && !bus_we && !bus_re));

  a_r2_ready_quiet: assert property (@(posedge clk) disable iff (rst)
    wd_ready |-> (busy && !bus_we && !bus_re));

  a_r3_first_write: assert property (@(posedge clk) disable iff (rst)
    $fell(wd_ready) |-> (bus_we && bus_addr == ADR_A && bus_wdata == DATA_W'(8'hAA)));

  a_r3_second_write: assert property (@(posedge clk) disable iff (rst)
    $fell(wd_ready) |=> (bus_we && bus_addr == ADR_B && bus_wdata == DATA_W'(8'h55)));

  a_r3_third_write: assert property (@(posedge clk) disable iff (rst)
    $fell(wd_ready) |-> ##2 (bus_we && bus_addr == ADR_A && bus_wdata == DATA_W'(8'hA0)));

  a_r4_read_follows: assert property (@(posedge clk) disable iff (rst)
    $fell(wd_ready) |-> ##4 (bus_re && !bus_we));

  a_r4_no_write_after_read: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> !bus_we);

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r7_poll_budget: assert property (@(posedge clk) disable iff (rst)
    reads_since_wr <= RW'(MAX_POLLS));

  a_r7_error_quiet: assert property (@(posedge clk) disable iff (rst)
    error |-> (!busy && !bus_we && !bus_re && !wd_ready));

  a_r9_strobes_apart: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re));

endmodule

bind flash_prog_loop fpl_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .LEN_W      (LEN_W),
  .MAX_POLLS  (MAX_POLLS),
  .CMD_ADDR_A (CMD_ADDR_A),
  .CMD_ADDR_B (CMD_ADDR_B)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .word_count (word_count),
  .wd_ready   (wd_ready),
  .busy       (busy),
  .done       (done),
  .error      (error),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata)
);

// File: tb/flash_prog_loop_bench.sv
module flash_prog_loop_bench;

  localparam int AW   = 12;
  localparam int DW   = 16;
  localparam int LW   = 8;
  localparam int MAXP = 24;
  localparam int MEMD = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [LW-1:0] word_count = '0;
  logic          wd_valid = 1'b0;
  logic [DW-1:0] wd_data = '0;
  logic          wd_ready, busy, done, error;
  logic          bus_we, bus_re;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  flash_prog_loop #(
    .ADDR_W (AW), .DATA_W (DW), .LEN_W (LW), .MAX_POLLS (MAXP)
  ) u_flash_prog_loop (
    .clk (clk), .rst (rst), .start (start), .base_addr (base_addr),
    .word_count (word_count), .wd_valid (wd_valid), .wd_data (wd_data),
    .wd_ready (wd_ready), .busy (busy), .done (done), .error (error),
    .bus_we (bus_we), .bus_re (bus_re), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata)
  );

  // ---------------- flash device model ----------------
  logic [DW-1:0] mem [0:MEMD-1];
  logic [DW-1:0] words [0:15];
  int            lat [0:15];
  int            exp_base = 0;
  logic          mem_clear = 1'b0;

  int            n_wr = 0, n_rd = 0, n_proto = 0;
  int            stage = 0, prog_idx = 0, left = 0;
  logic          pending = 1'b0;
  logic [AW-1:0] pa = '0;
  logic [DW-1:0] pd = '0;

  always @(posedge clk) begin
    if (mem_clear) begin
      for (int i = 0; i < MEMD; i++) mem[i] <= 16'hFFFF;
      stage <= 0; prog_idx <= 0; pending <= 1'b0; bus_rdata <= '0;
    end else begin
      if (bus_we) begin
        n_wr <= n_wr + 1;
        case (stage)
          0: if (bus_addr == 12'h555 && bus_wdata == 16'h00AA) stage <= 1;
             else n_proto <= n_proto + 1;
          1: if (bus_addr == 12'h2AA && bus_wdata == 16'h0055) stage <= 2;
             else begin n_proto <= n_proto + 1; stage <= 0; end
          2: if (bus_addr == 12'h555 && bus_wdata == 16'h00A0) stage <= 3;
             else begin n_proto <= n_proto + 1; stage <= 0; end
          default: begin
            if (int'(bus_addr) != exp_base + prog_idx || bus_wdata != words[prog_idx])
              n_proto <= n_proto + 1;
            pending  <= 1'b1;
            pa       <= bus_addr;
            pd       <= bus_wdata;
            left     <= lat[prog_idx];
            prog_idx <= prog_idx + 1;
            stage    <= 0;
          end
        endcase
      end
      if (bus_re) begin
        n_rd <= n_rd + 1;
        if (pending && bus_addr == pa) begin
          if (left > 0) begin
            bus_rdata <= ~pd;
            left <= left - 1;
          end else begin
            bus_rdata <= pd;
            mem[pa]   <= pd;
            pending   <= 1'b0;
          end
        end else begin
          bus_rdata <= mem[bus_addr];
          if (pending) n_proto <= n_proto + 1;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    @(negedge clk); mem_clear = 1'b1;
    @(negedge clk); mem_clear = 1'b0;
  endtask

  int wr0, rd0, pr0, wr_at10;
  bit saw_done, saw_err;

  task automatic run_xfer(input int base, input int len, input int first_gap,
                          input bit poke);
    int idx = 0;
    int gap = first_gap;
    int cyc = 0;
    wr0 = n_wr; rd0 = n_rd; pr0 = n_proto; wr_at10 = -1;
    exp_base = base;
    @(negedge clk);
    base_addr = AW'(base); word_count = LW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!(done || error) && cyc < 20000) begin
      if (wd_valid) begin
        idx++; wd_valid = 1'b0; gap = $urandom_range(0, 3);
      end
      if (wd_ready && !wd_valid) begin
        if (gap == 0) begin wd_valid = 1'b1; wd_data = words[idx]; end
        else gap--;
      end
      if (poke && cyc == 6) begin
        start = 1'b1; base_addr = AW'(base ^ 'h800); word_count = LW'(1);
      end else start = 1'b0;
      if (cyc == 10) wr_at10 = n_wr - wr0;
      @(negedge clk);
      cyc++;
    end
    saw_done = done;
    saw_err  = error;
    wd_valid = 1'b0;
    start    = 1'b0;
  endtask

  function automatic int exp_reads(input int len);
    int s = 0;
    for (int i = 0; i < len; i++) s += lat[i] + 1;
    return s;
  endfunction

  task automatic verify_run(input int base, input int len, input string tag);
    int bad = 0;
    check(saw_done && !saw_err, "R6", {tag, " done seen"}, saw_done, 1);
    check(n_wr - wr0 == 4 * len, "R3", {tag, " write count"}, n_wr - wr0, 4 * len);
    check(n_proto - pr0 == 0, "R3", {tag, " command order/target"}, n_proto - pr0, 0);
    check(n_rd - rd0 == exp_reads(len), "R4", {tag, " poll reads"}, n_rd - rd0, exp_reads(len));
    for (int i = 0; i < len; i++) if (mem[base + i] != words[i]) bad++;
    check(bad == 0, "R5", {tag, " words at base+i"}, bad, 0);
    @(negedge clk);
    check(!done && !busy, "R6", {tag, " single done pulse"}, {done, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not end, actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    clear_mem();
    repeat (4) @(negedge clk);
    check({busy, done, error, wd_ready, bus_we, bus_re} == 6'b0, "R10", "reset outputs",
          {busy, done, error, wd_ready, bus_we, bus_re}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1: zero-length request
    wr0 = n_wr; rd0 = n_rd;
    base_addr = 12'h100; word_count = '0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done && !busy, "R1", "zero length done next cycle", {done, busy}, 2'b10);
    @(negedge clk);
    check(n_wr == wr0 && n_rd == rd0 && !done, "R1", "zero length no bus",
          n_wr - wr0 + n_rd - rd0, 0);

    // R1/R3/R4: single word of all ones, immediate completion
    clear_mem();
    words[0] = 16'hFFFF; lat[0] = 0;
    run_xfer('h100, 1, 0, 1'b0);
    verify_run('h100, 1, "single ffff");

    // R2: long hold-off on the first word; range spans the command address
    clear_mem();
    words[0] = 16'h0000; words[1] = 16'h1234; words[2] = 16'hFFFF; words[3] = 16'h00AA;
    lat[0] = 5; lat[1] = 0; lat[2] = 9; lat[3] = 1;
    run_xfer('h553, 4, 15, 1'b0);
    check(wr_at10 == 0, "R2", "no write before handshake", wr_at10, 0);
    verify_run('h553, 4, "directed four");

    // random runs
    for (int r = 0; r < 8; r++) begin
      int len  = $urandom_range(1, 8);
      int base = $urandom_range(0, MEMD - 16);
      clear_mem();
      for (int i = 0; i < len; i++) begin
        words[i] = DW'($urandom);
        lat[i]   = $urandom_range(0, 12);
      end
      run_xfer(base, len, $urandom_range(0, 4), 1'b0);
      verify_run(base, len, "random");
    end

    // R8: start pulse in mid-run is ignored
    clear_mem();
    for (int i = 0; i < 5; i++) begin words[i] = DW'($urandom); lat[i] = 2; end
    run_xfer('h040, 5, 0, 1'b1);
    verify_run('h040, 5, "mid-run start");
    check(mem['h040 ^ 'h800] == 16'hFFFF, "R8", "other base untouched",
          mem['h040 ^ 'h800], 16'hFFFF);

    // R7: device never confirms
    clear_mem();
    words[0] = 16'hBEEF; words[1] = 16'h0101; words[2] = 16'h0202;
    lat[0] = 1000000; lat[1] = 0; lat[2] = 0;
    run_xfer('h200, 3, 0, 1'b0);
    check(saw_err && !saw_done && !busy, "R7", "error raised, busy low",
          {saw_err, saw_done, busy}, 3'b100);
    check(n_rd - rd0 == MAXP, "R7", "reads equal poll budget", n_rd - rd0, MAXP);
    check(n_wr - wr0 == 4, "R7", "no later word written", n_wr - wr0, 4);
    check(mem['h201] == 16'hFFFF && mem['h202] == 16'hFFFF, "R7", "later addresses untouched",
          mem['h201], 16'hFFFF);
    wr0 = n_wr; rd0 = n_rd;
    repeat (10) @(negedge clk);
    check(n_wr == wr0 && n_rd == rd0 && error && !wd_ready, "R7", "stopped and flag held",
          n_wr - wr0 + n_rd - rd0, 0);

    // R7: error clears on the next start
    clear_mem();
    words[0] = 16'h5A5A; lat[0] = 3;
    @(negedge clk);
    base_addr = 12'h300; word_count = LW'(1); start = 1'b1; exp_base = 'h300;
    wr0 = n_wr; rd0 = n_rd; pr0 = n_proto;
    @(negedge clk); start = 1'b0;
    check(!error && busy, "R7", "error cleared at start", {error, busy}, 2'b01);
    wd_valid = 1'b1; wd_data = words[0];
    @(negedge clk); wd_valid = 1'b0;
    while (!done && !error && (n_rd - rd0) < 100) @(negedge clk);
    saw_done = done; saw_err = error;
    verify_run('h300, 1, "after error");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule